// File: doc/BRIEF.md
# Low Power Mode Clock Controller

This block sits between a processor core and its clock tree and parks the machine in one of four low-power states. A one-cycle idle request makes the block sample three configuration bits (a power-down bit, a stop-clock bit and a stall bit) and pick a state. Each state gates its own set of clock enables and says whether the instruction pipeline survives the sleep.

An interrupt request wakes the block. After the wake count for the chosen state, it raises a single-cycle resume pulse and hands control back to the running core. The clock enables stay in their sleep pattern during the wake count. The PLL enable comes back at the start of the wake count so the clock source can settle.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: After synchronous reset the block is running: core_clk_en, periph_clk_en and pll_en are 1; pipe_flush and resume are 0.
- R2: The state is decoded from {pd_bit, stck_bit, stall_bit} at the clock edge that samples idle_req high while running. pd_bit=0 selects halt. pd_bit=1 with stck_bit=0 selects core-off. pd_bit=1, stck_bit=1, stall_bit=0 selects core+peripheral-off. All three at 1 selects all-off. Changes of the bits after that edge have no effect until the next entry.
- R3: In halt, from the cycle after the entry edge: core_clk_en=1, periph_clk_en=1, pll_en=1, pipe_flush=0.
- R4: In core-off: core_clk_en=0, periph_clk_en=1, pll_en=1, pipe_flush=0.
- R5: In core+peripheral-off: core_clk_en=0, periph_clk_en=0, pll_en=1, pipe_flush=1.
- R6: In all-off: core_clk_en=0, periph_clk_en=0, pll_en=0, pipe_flush=1.
- R7: Let the edge that samples irq high while asleep be edge 0. resume is high only in the cycle after edge L. L is WAKE_SHORT (default 2) for halt and core-off, WAKE_MID (default 6) for core+peripheral-off, and WAKE_ALL (default 24) for all-off.
- R8: During the wake count, core_clk_en, periph_clk_en and pipe_flush keep their sleep values and pll_en is 1. irq held or pulsed during the count neither restarts it nor moves resume. In the resume cycle all three enables are 1 and pipe_flush is 0, and the block is running from the next cycle.
- R9: irq while running has no effect. idle_req while asleep or counting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Request to enter the configured low-power state |
| pd_bit | input | 1 | Power-down configuration bit |
| stck_bit | input | 1 | Stop-clock configuration bit |
| stall_bit | input | 1 | Stall configuration bit |
| irq | input | 1 | Wake-up interrupt request |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| pipe_flush | output | 1 | Pipeline contents are lost and must be refilled |
| resume | output | 1 | One-cycle pulse: execution restarts |

## Verification
The hardest case is an interrupt that lands inside the wake count, because the count is only visible through the time at which resume appears. The bench holds irq high across the whole long count of the core+peripheral-off state and confirms that resume still fires at edge 6. It also toggles the configuration bits after entry, and checks every cycle of the count to see that the sleep pattern and the latched state hold until resume.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LP_HALT     = 2'd0,
        LP_CORE_OFF = 2'd1,
        LP_CP_OFF   = 2'd2,
        LP_ALL_OFF  = 2'd3
    } lp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2,
        ST_RES   = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic core_en;
        logic periph_en;
        logic pll_en;
        logic flush;
    } lp_gate_t;

    function automatic lp_gate_t sleep_gates(input lp_mode_e m);
        lp_gate_t g;
        case (m)
            LP_HALT:     g = '{core_en: 1'b1, periph_en: 1'b1, pll_en: 1'b1, flush: 1'b0};
            LP_CORE_OFF: g = '{core_en: 1'b0, periph_en: 1'b1, pll_en: 1'b1, flush: 1'b0};
            LP_CP_OFF:   g = '{core_en: 1'b0, periph_en: 1'b0, pll_en: 1'b1, flush: 1'b1};
            default:     g = '{core_en: 1'b0, periph_en: 1'b0, pll_en: 1'b0, flush: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
    import lpm_pkg::*;
(
    input  logic     pd,
    input  logic     stck,
    input  logic     stall,
    output lp_mode_e mode
);
    always_comb begin
        if (!pd)        mode = LP_HALT;
        else if (!stck) mode = LP_CORE_OFF;
        else if (!stall) mode = LP_CP_OFF;
        else            mode = LP_ALL_OFF;
    end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] start_val,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= start_val;
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - CW'(1);
        end
    end

    assign expired = active && (cnt == '0);

    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0 && !start) |=> (cnt == $past(cnt) - CW'(1)));

    p_expire_once_r7: assert property (@(posedge clk) disable iff (rst)
        (expired && !start) |=> !expired);
endmodule

// File: rtl/lpm_gate_map.sv
module lpm_gate_map
    import lpm_pkg::*;
(
    input  lp_state_e state,
    input  lp_mode_e  mode,
    output lp_gate_t  gates
);
    lp_gate_t slp;
    assign slp = sleep_gates(mode);

    always_comb begin
        case (state)
            ST_SLEEP: gates = slp;
            ST_WAKE:  gates = '{core_en: slp.core_en, periph_en: slp.periph_en,
                                pll_en: 1'b1, flush: slp.flush};
            default:  gates = '{core_en: 1'b1, periph_en: 1'b1, pll_en: 1'b1, flush: 1'b0};
        endcase
    end
endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
    import lpm_pkg::*;
#(
    parameter int WAKE_SHORT = 2,
    parameter int WAKE_MID   = 6,
    parameter int WAKE_ALL   = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic idle_req,
    input  logic pd_bit,
    input  logic stck_bit,
    input  logic stall_bit,
    input  logic irq,
    output logic core_clk_en,
    output logic periph_clk_en,
    output logic pll_en,
    output logic pipe_flush,
    output logic resume
);
    localparam int MAXL = (WAKE_ALL > WAKE_MID) ?
                          ((WAKE_ALL > WAKE_SHORT) ? WAKE_ALL : WAKE_SHORT) :
                          ((WAKE_MID > WAKE_SHORT) ? WAKE_MID : WAKE_SHORT);
    localparam int CW = $clog2(MAXL + 1);

    lp_state_e     state;
    lp_mode_e      mode_q;
    lp_mode_e      mode_in;
    lp_gate_t      gates;
    logic          expired;
    logic          wake_start;
    logic [CW-1:0] wake_val;

    lpm_mode_decode u_dec (
        .pd    (pd_bit),
        .stck  (stck_bit),
        .stall (stall_bit),
        .mode  (mode_in)
    );

    always_comb begin
        case (mode_q)
            LP_HALT, LP_CORE_OFF: wake_val = CW'(WAKE_SHORT - 1);
            LP_CP_OFF:            wake_val = CW'(WAKE_MID - 1);
            default:              wake_val = CW'(WAKE_ALL - 1);
        endcase
    end

    assign wake_start = (state == ST_SLEEP) && irq;

    lpm_wake_timer #(.CW(CW)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start     (wake_start),
        .start_val (wake_val),
        .expired   (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RUN;
            mode_q <= LP_HALT;
        end else begin
            case (state)
                ST_RUN: if (idle_req) begin
                    state  <= ST_SLEEP;
                    mode_q <= mode_in;
                end
                ST_SLEEP: if (irq) state <= ST_WAKE;
                ST_WAKE:  if (expired) state <= ST_RES;
                default:  state <= ST_RUN;
            endcase
        end
    end

    lpm_gate_map u_map (
        .state (state),
        .mode  (mode_q),
        .gates (gates)
    );

    assign core_clk_en   = gates.core_en;
    assign periph_clk_en = gates.periph_en;
    assign pll_en        = gates.pll_en;
    assign pipe_flush    = gates.flush;
    assign resume        = (state == ST_RES);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN && $past(state) != ST_RUN) |-> $stable(mode_q));

    p_resume_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume);

    p_resume_clocks_r8: assert property (@(posedge clk) disable iff (rst)
        resume |-> (core_clk_en && periph_clk_en && pll_en && !pipe_flush));

    p_flush_gated_r5: assert property (@(posedge clk) disable iff (rst)
        pipe_flush |-> (!core_clk_en && !periph_clk_en));

    p_pll_off_r6: assert property (@(posedge clk) disable iff (rst)
        !pll_en |-> (state == ST_SLEEP && mode_q == LP_ALL_OFF));

    p_no_wake_run_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> (state == ST_RUN || state == ST_SLEEP));
endmodule

// File: tb/lpm_clock_ctrl_test.sv
module lpm_clock_ctrl_test;
    logic clk = 1'b0;
    logic rst, idle_req, pd_bit, stck_bit, stall_bit, irq;
    logic core_clk_en, periph_clk_en, pll_en, pipe_flush, resume;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpm_clock_ctrl uut (
        .clk(clk), .rst(rst), .idle_req(idle_req), .pd_bit(pd_bit),
        .stck_bit(stck_bit), .stall_bit(stall_bit), .irq(irq),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .pll_en(pll_en), .pipe_flush(pipe_flush), .resume(resume)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {core_clk_en, periph_clk_en, pll_en, pipe_flush, resume};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter(input logic p, input logic s, input logic t, input logic [4:0] exp, input string tag);
        pd_bit = p; stck_bit = s; stall_bit = t; idle_req = 1'b1;
        step();
        idle_req = 1'b0;
        chk(tag, outs(), exp);
    endtask

    // irq sampled at next edge (edge 0); resume expected after edge L only
    task automatic wake(input int lat, input logic [4:0] slp, input bit hold, input string tag);
        logic [4:0] cnt_pat;
        cnt_pat = {slp[4], slp[3], 1'b1, slp[1], 1'b0};
        irq = 1'b1;
        step();
        if (!hold) irq = 1'b0;
        chk({tag, " R8 count start"}, outs(), cnt_pat);
        for (int i = 1; i < lat; i++) begin
            if (!hold) irq = i[0];
            step();
            chk({tag, " R8 counting"}, outs(), cnt_pat);
        end
        step();
        irq = 1'b0;
        chk({tag, " R7 resume"}, outs(), 5'b11101);
        step();
        chk({tag, " R8 back to run"}, outs(), 5'b11100);
    endtask

    task automatic t_reset();
        rst = 1'b1; idle_req = 0; pd_bit = 0; stck_bit = 0; stall_bit = 0; irq = 0;
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 reset state", outs(), 5'b11100);
    endtask

    task automatic t_halt();
        enter(0, 0, 0, 5'b11100, "R3 halt gates");
        wake(2, 5'b11100, 0, "R7 halt");
    endtask

    task automatic t_halt_odd_bits();
        enter(0, 1, 1, 5'b11100, "R2 pd=0 selects halt");
        wake(2, 5'b11100, 0, "R2 halt odd bits");
    endtask

    task automatic t_core_off();
        enter(1, 0, 1, 5'b01100, "R4 core-off gates");
        step();
        chk("R4 core-off steady", outs(), 5'b01100);
        wake(2, 5'b01100, 0, "R7 core-off");
    endtask

    task automatic t_cp_off();
        enter(1, 1, 0, 5'b00110, "R5 core+periph gates");
        pd_bit = 0; stck_bit = 0; stall_bit = 1;
        step();
        chk("R2 bits changed after entry", outs(), 5'b00110);
        idle_req = 1'b1;
        step();
        idle_req = 1'b0;
        chk("R9 idle_req while asleep", outs(), 5'b00110);
        wake(6, 5'b00110, 1, "R8 held irq core+periph");
    endtask

    task automatic t_all_off();
        enter(1, 1, 1, 5'b00010, "R6 all-off gates");
        wake(24, 5'b00010, 0, "R7 all-off");
    endtask

    task automatic t_irq_run();
        irq = 1'b1;
        step(); step();
        irq = 1'b0;
        chk("R9 irq while running", outs(), 5'b11100);
        step();
        chk("R9 no late resume", outs(), 5'b11100);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_halt();
        t_halt_odd_bits();
        t_core_off();
        t_cp_off();
        t_all_off();
        t_irq_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule